// File: doc/BRIEF.md
# Direct-Mapped Branch Target Buffer

This block sits beside the instruction fetch stage and guesses where the next fetch should go. Every cycle it takes the current fetch address and looks it up in a direct-mapped table. It returns three things without waiting for a clock: whether the address hits a recorded branch, whether that branch is predicted taken, and the target address recorded for it.

When a branch resolves later in the pipeline, the back end reports four items: the branch address, its real target and whether it was taken, plus a strobe that marks the report valid. The table learns from each report. Each entry keeps a tag, a target and a two-bit saturating history counter, and the counter decides the taken prediction. A flush input forgets every recorded branch at once.

Top module: `btb_predictor`

## Requirements
- R1: After reset no entry is valid, so `hit`, `pred_taken` and `pred_target` are all 0 for any fetch address until a branch has been allocated.
- R2: The table index is address bits [8:2] (128 entries) and the tag is bits [31:9]. An address hits when the entry at its index is valid and its tag matches. Bits [1:0] play no part in the lookup.
- R3: On a miss, `pred_taken` is 0 and `pred_target` is 0.
- R4: The history counter uses these codes: 00 strong not-taken, 01 weak not-taken, 10 weak taken, 11 strong taken. On a hit, `pred_taken` is 1 exactly when the counter is 10 or 11, and `pred_target` is the stored target.
- R5: A resolved branch that is taken and misses the table is allocated. The entry is marked valid, gets the branch tag and the actual target, and its counter starts at 10 (weak taken).
- R6: A resolved branch that is not taken and misses the table changes nothing. Whatever already occupies that index stays in place.
- R7: A resolved branch that hits moves its counter one step toward the outcome. The counter saturates at 11 when taken and at 00 when not taken.
- R8: A resolved branch that hits always has its stored target replaced by the reported target, whether or not it was taken.
- R9: A lookup in the same cycle as a write to the same index returns the entry as it was before the write. The new contents appear from the next cycle on.
- R10: Flush invalidates every entry in one cycle, and the next cycle misses everywhere. A resolve in the same cycle as a flush is dropped.
- R11: A taken miss whose index is held by a different tag replaces that entry, and the old branch then misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Invalidate all entries |
| fetch_addr | input | 32 | Address being fetched |
| hit | output | 1 | Fetch address matches a valid entry |
| pred_taken | output | 1 | Predicted taken |
| pred_target | output | 32 | Predicted target, 0 on miss |
| rslv_valid | input | 1 | A branch resolution is reported this cycle |
| rslv_addr | input | 32 | Address of the resolved branch |
| rslv_target | input | 32 | Actual target of the resolved branch |
| rslv_taken | input | 1 | Resolved outcome |

## Verification
A wrong index or tag slice shows up at the ports as missed hits or false hits. A branch that has just been allocated will not read back one cycle later, or it will alias with an address at another index. A counter that has drifted changes `pred_taken` on the first lookup after the update that moved it. The stepping is exercised through runs of several updates in a row, because a single update can hide a wrong saturation edge. Because the lookup is combinational and every write takes effect on the next edge, each fault becomes visible within one cycle of the resolve or flush that caused it.

// File: rtl/btb_pkg.sv
package btb_pkg;

  typedef enum logic [1:0] {
    CTR_SNT = 2'b00,
    CTR_WNT = 2'b01,
    CTR_WT  = 2'b10,
    CTR_ST  = 2'b11
  } ctr_e;

  // one saturating step toward the outcome
  function automatic ctr_e ctr_step(input ctr_e cur, input logic taken);
    ctr_e nxt;
    nxt = cur;
    case (cur)
      CTR_SNT: nxt = taken ? CTR_WNT : CTR_SNT;
      CTR_WNT: nxt = taken ? CTR_WT  : CTR_SNT;
      CTR_WT:  nxt = taken ? CTR_ST  : CTR_WNT;
      CTR_ST:  nxt = taken ? CTR_ST  : CTR_WT;
      default: nxt = CTR_WT;
    endcase
    return nxt;
  endfunction

  function automatic logic ctr_says_taken(input ctr_e cur);
    return cur == CTR_WT || cur == CTR_ST;
  endfunction

endpackage

// File: rtl/btb_entry_store.sv
module btb_entry_store
  import btb_pkg::*;
#(
  parameter int IDX_W  = 7,
  parameter int TAG_W  = 23,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  // lookup port
  input  logic [IDX_W-1:0]  a_idx,
  output logic              a_valid,
  output logic [TAG_W-1:0]  a_tag,
  output logic [DATA_W-1:0] a_tgt,
  output ctr_e              a_ctr,
  // update-side read port
  input  logic [IDX_W-1:0]  b_idx,
  output logic              b_valid,
  output logic [TAG_W-1:0]  b_tag,
  output ctr_e              b_ctr,
  // write port
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [DATA_W-1:0] wr_tgt,
  input  ctr_e              wr_ctr
);
  localparam int DEPTH = 1 << IDX_W;

  logic [DEPTH-1:0]  valid_q;
  logic [TAG_W-1:0]  tag_q [DEPTH];
  logic [DATA_W-1:0] tgt_q [DEPTH];
  ctr_e              ctr_q [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n)           valid_q <= '0;
    else if (flush)       valid_q <= '0;
    else if (wr_en)       valid_q[wr_idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (wr_en && !flush) begin
      tag_q[wr_idx] <= wr_tag;
      tgt_q[wr_idx] <= wr_tgt;
      ctr_q[wr_idx] <= wr_ctr;
    end
  end

  // both reads are combinational and see pre-write contents
  assign a_valid = valid_q[a_idx];
  assign a_tag   = tag_q[a_idx];
  assign a_tgt   = tgt_q[a_idx];
  assign a_ctr   = ctr_q[a_idx];
  assign b_valid = valid_q[b_idx];
  assign b_tag   = tag_q[b_idx];
  assign b_ctr   = ctr_q[b_idx];

endmodule

// File: rtl/btb_update_ctl.sv
module btb_update_ctl
  import btb_pkg::*;
#(
  parameter int TAG_W = 23
) (
  input  logic             flush,
  input  logic             rslv_valid,
  input  logic             rslv_taken,
  input  logic [TAG_W-1:0] rslv_tag,
  input  logic             cur_valid,
  input  logic [TAG_W-1:0] cur_tag,
  input  ctr_e             cur_ctr,
  output logic             upd_hit,
  output logic             upd_alloc,
  output logic             wr_en,
  output ctr_e             wr_ctr
);
  always_comb begin
    upd_hit   = rslv_valid && !flush && cur_valid && (cur_tag == rslv_tag);
    upd_alloc = rslv_valid && !flush && rslv_taken && !upd_hit;
    wr_en     = upd_hit || upd_alloc;
    wr_ctr    = upd_hit ? ctr_step(cur_ctr, rslv_taken) : CTR_WT;
  end
endmodule

// File: rtl/btb_predictor.sv
module btb_predictor
  import btb_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic [ADDR_W-1:0] fetch_addr,
  output logic              hit,
  output logic              pred_taken,
  output logic [ADDR_W-1:0] pred_target,
  input  logic              rslv_valid,
  input  logic [ADDR_W-1:0] rslv_addr,
  input  logic [ADDR_W-1:0] rslv_target,
  input  logic              rslv_taken
);
  localparam int TAG_LSB = IDX_W + 2;
  localparam int TAG_W   = ADDR_W - TAG_LSB;

  function automatic logic [IDX_W-1:0] idx_of(input logic [ADDR_W-1:0] a);
    return a[TAG_LSB-1:2];
  endfunction

  function automatic logic [TAG_W-1:0] tag_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:TAG_LSB];
  endfunction

  // byte offset bits never take part in the lookup
  logic unused_byte_bits;
  assign unused_byte_bits = ^{fetch_addr[1:0], rslv_addr[1:0]};

  logic              a_valid, b_valid;
  logic [TAG_W-1:0]  a_tag, b_tag;
  logic [ADDR_W-1:0] a_tgt;
  ctr_e              a_ctr, b_ctr;

  // named events for the checker
  logic upd_hit, upd_alloc, wr_en;
  ctr_e wr_ctr;

  btb_entry_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(ADDR_W)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .flush   (flush),
    .a_idx   (idx_of(fetch_addr)),
    .a_valid (a_valid),
    .a_tag   (a_tag),
    .a_tgt   (a_tgt),
    .a_ctr   (a_ctr),
    .b_idx   (idx_of(rslv_addr)),
    .b_valid (b_valid),
    .b_tag   (b_tag),
    .b_ctr   (b_ctr),
    .wr_en   (wr_en),
    .wr_idx  (idx_of(rslv_addr)),
    .wr_tag  (tag_of(rslv_addr)),
    .wr_tgt  (rslv_target),
    .wr_ctr  (wr_ctr)
  );

  btb_update_ctl #(.TAG_W(TAG_W)) u_upd (
    .flush      (flush),
    .rslv_valid (rslv_valid),
    .rslv_taken (rslv_taken),
    .rslv_tag   (tag_of(rslv_addr)),
    .cur_valid  (b_valid),
    .cur_tag    (b_tag),
    .cur_ctr    (b_ctr),
    .upd_hit    (upd_hit),
    .upd_alloc  (upd_alloc),
    .wr_en      (wr_en),
    .wr_ctr     (wr_ctr)
  );

  always_comb begin
    hit         = a_valid && (a_tag == tag_of(fetch_addr));
    pred_taken  = hit && ctr_says_taken(a_ctr);
    pred_target = hit ? a_tgt : '0;
  end

endmodule

// File: rtl/btb_predictor_chk.sv
module btb_predictor_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              flush,
  input logic [ADDR_W-1:0] fetch_addr,
  input logic              hit,
  input logic              pred_taken,
  input logic [ADDR_W-1:0] pred_target,
  input logic              rslv_valid,
  input logic [ADDR_W-1:0] rslv_addr,
  input logic [ADDR_W-1:0] rslv_target,
  input logic              rslv_taken,
  input logic              upd_hit
);
  // R3
  miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |-> (pred_target == '0));

  // R4
  taken_needs_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pred_taken |-> hit);

  // R10
  flush_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !hit);

  // R8
  write_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rslv_valid && !flush && (rslv_taken || upd_hit)) |=>
      ((fetch_addr[ADDR_W-1:2] != $past(rslv_addr[ADDR_W-1:2])) ||
       (hit && pred_target == $past(rslv_target))));

  // R6
  notaken_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rslv_valid && !rslv_taken && !upd_hit && !flush) |=>
      ((fetch_addr[ADDR_W-1:2] != $past(rslv_addr[ADDR_W-1:2])) || !hit));
endmodule

bind btb_predictor btb_predictor_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .flush       (flush),
  .fetch_addr  (fetch_addr),
  .hit         (hit),
  .pred_taken  (pred_taken),
  .pred_target (pred_target),
  .rslv_valid  (rslv_valid),
  .rslv_addr   (rslv_addr),
  .rslv_target (rslv_target),
  .rslv_taken  (rslv_taken),
  .upd_hit     (upd_hit)
);

// File: tb/tb_btb_predictor.sv
`timescale 1ns/1ps
module tb_btb_predictor;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush = 1'b0;
  logic [31:0] fetch_addr = '0;
  logic        hit, pred_taken;
  logic [31:0] pred_target;
  logic        rslv_valid = 1'b0;
  logic [31:0] rslv_addr = '0;
  logic [31:0] rslv_target = '0;
  logic        rslv_taken = 1'b0;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #10 clk = ~clk;

  btb_predictor dut (
    .clk(clk), .rst_n(rst_n), .flush(flush), .fetch_addr(fetch_addr),
    .hit(hit), .pred_taken(pred_taken), .pred_target(pred_target),
    .rslv_valid(rslv_valid), .rslv_addr(rslv_addr),
    .rslv_target(rslv_target), .rslv_taken(rslv_taken)
  );

  // reference table built from the requirements
  bit          m_valid [128];
  logic [22:0] m_tag   [128];
  logic [31:0] m_tgt   [128];
  int          m_ctr   [128];

  function automatic int ix(input logic [31:0] a);
    return int'((a >> 2) & 32'd127);
  endfunction

  function automatic logic [22:0] tg(input logic [31:0] a);
    return a[31:9];
  endfunction

  function automatic int moved(input int c, input bit tk);
    if (tk) return (c == 3) ? 3 : c + 1;
    return (c == 0) ? 0 : c - 1;
  endfunction

  task automatic model_apply(input bit rv, input logic [31:0] ra,
                             input logic [31:0] rt, input bit tk, input bit fl);
    int i;
    if (fl) begin
      for (int k = 0; k < 128; k++) m_valid[k] = 0;
      return;
    end
    if (!rv) return;
    i = ix(ra);
    if (m_valid[i] && m_tag[i] == tg(ra)) begin
      m_ctr[i] = moved(m_ctr[i], tk);
      m_tgt[i] = rt;
    end else if (tk) begin
      m_valid[i] = 1;
      m_tag[i]   = tg(ra);
      m_tgt[i]   = rt;
      m_ctr[i]   = 2;
    end
  endtask

  task automatic cyc(input logic [31:0] fa, input bit rv, input logic [31:0] ra,
                     input logic [31:0] rt, input bit tk, input bit fl,
                     input string req);
    bit e_hit, e_tk;
    logic [31:0] e_tgt;
    int i;
    @(negedge clk);
    fetch_addr = fa; rslv_valid = rv; rslv_addr = ra;
    rslv_target = rt; rslv_taken = tk; flush = fl;
    #1;
    i = ix(fa);
    e_hit = m_valid[i] && m_tag[i] == tg(fa);
    e_tk  = e_hit && m_ctr[i] >= 2;
    e_tgt = e_hit ? m_tgt[i] : 32'd0;
    checks++;
    if (hit !== e_hit || pred_taken !== e_tk || pred_target !== e_tgt) begin
      failures++;
      $display("FAIL %s addr=%h actual hit=%b tk=%b tgt=%h expected hit=%b tk=%b tgt=%h",
               req, fa, hit, pred_taken, pred_target, e_hit, e_tk, e_tgt);
    end
    @(posedge clk);
    model_apply(rv, ra, rt, tk, fl);
  endtask

  localparam logic [31:0] A  = 32'h0000_1004;  // index 1
  localparam logic [31:0] B  = 32'h0000_2004;  // index 1, other tag
  localparam logic [31:0] C  = 32'h0000_0108;  // index 66
  localparam logic [31:0] T1 = 32'h0000_8000;
  localparam logic [31:0] T2 = 32'h0000_9abc;

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] pool [8];
    void'($urandom(32'd2024));
    for (int k = 0; k < 128; k++) begin
      m_valid[k] = 0; m_tag[k] = '0; m_tgt[k] = '0; m_ctr[k] = 0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    cyc(A, 0, 0, 0, 0, 0, "R1 reset miss");
    cyc(C, 0, 0, 0, 0, 0, "R1 reset miss other index");
    // allocate A; lookup in the same cycle sees the old (empty) entry
    cyc(A, 1, A, T1, 1, 0, "R9 same-cycle read old");
    cyc(A, 0, 0, 0, 0, 0, "R5 allocated weak taken");
    cyc(A | 32'd3, 0, 0, 0, 0, 0, "R2 byte bits ignored");
    cyc(A ^ 32'h0000_0200, 0, 0, 0, 0, 0, "R2 tag mismatch misses");
    // hit update with new target, lookup same cycle still old
    cyc(A, 1, A, T2, 1, 0, "R9 old target during write");
    cyc(A, 1, A, T2, 1, 0, "R8 target replaced, R7 strong");
    cyc(A, 1, A, T1, 0, 0, "R7 saturated at strong taken");
    cyc(A, 1, A, T1, 0, 0, "R4 weak taken predicts taken");
    cyc(A, 1, A, T1, 0, 0, "R4 weak not-taken hit no predict");
    cyc(A, 1, A, T2, 0, 0, "R7 strong not-taken");
    cyc(A, 1, A, T2, 1, 0, "R7 saturated at strong not-taken");
    cyc(A, 0, 0, 0, 0, 0, "R8 target replaced on not-taken hit");
    // not-taken miss at occupied index leaves A alone
    cyc(A, 1, B, T1, 0, 0, "R4 weak not-taken");
    cyc(A, 0, 0, 0, 0, 0, "R6 occupant kept");
    cyc(B, 0, 0, 0, 0, 0, "R3 miss outputs zero");
    // taken miss replaces
    cyc(B, 1, B, T1, 1, 0, "R9 alias write");
    cyc(A, 0, 0, 0, 0, 0, "R11 old branch evicted");
    cyc(B, 0, 0, 0, 0, 0, "R11 new branch present");
    // flush with simultaneous allocation
    cyc(C, 1, C, T2, 1, 1, "R10 flush cycle lookup");
    cyc(C, 0, 0, 0, 0, 0, "R10 resolve dropped under flush");
    cyc(B, 0, 0, 0, 0, 0, "R10 all entries cleared");
    cyc(C, 1, C, T2, 1, 0, "R5 alloc after flush");
    cyc(C, 0, 0, 0, 0, 1, "R5 alloc visible");
    cyc(C, 0, 0, 0, 0, 0, "R10 cleared after flush");

    // constrained random traffic over a small aliasing pool
    for (int k = 0; k < 4; k++) begin
      pool[k]     = $urandom & 32'hffff_fffc;
      pool[k + 4] = pool[k] ^ 32'h0010_0000;
    end
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] fa, ra;
      fa = pool[$urandom % 8] | ($urandom % 4);
      ra = pool[$urandom % 8] | ($urandom % 4);
      cyc(fa, ($urandom % 2) == 1, ra, $urandom, ($urandom % 3) != 0,
          ($urandom % 64) == 0, "R2 R4 R7 random");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule